// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands and returns their full-width product with no clock and no state. Each bit of the multiplier operand `q` gates a copy of the multiplicand `m` through a row of AND gates. The rows that result are summed by a grid of full-adder cells.

Inside the grid, every cell sends its carry down to the next row, one column to the left. No carry travels sideways along an intermediate row, so each of those rows settles in one full-adder delay. The lowest bit of every row leaves the grid as one finished low product bit. After the last row, a single ripple chain of full adders merges the leftover sum and carry vectors into the upper half of the product.

The operand width is a parameter, and its default is 4 bits, which gives an 8-bit product. The block fits wherever a small, fixed-latency product is needed inside a combinational datapath, such as a simple arithmetic unit that selects between a sum and a product.

Top module: `csaMultiplier`

## Requirements
- R1: For every pair of 4-bit unsigned operands, `product` equals the arithmetic product m × q as an 8-bit unsigned number.
- R2: When either operand is zero, every bit of `product` is 0.
- R3: Bit 0 of `product` is 1 exactly when bit 0 of `m` and bit 0 of `q` are both 1.
- R4: When either operand equals 1, `product` equals the other operand, zero-extended to 8 bits.
- R5: `product` never exceeds 225. The pair 15 × 15 gives 225 (0xE1), and no bit is lost at the top.
- R6: 14 × 11 gives 154, and 9 × 5 gives 45.
- R7: The pairs 0 × 10, 5 × 5, 12 × 13 and 15 × 10 give 0, 25, 156 and 150.
- R8: Swapping the operands does not change `product`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m | input | 4 | Multiplicand, unsigned |
| q | input | 4 | Multiplier, unsigned; bit j selects partial-product row j |
| product | output | 8 | Unsigned product m × q |

## Verification
The block has no registers. A fault in any partial-product gate or adder cell therefore shows up at `product` as soon as the inputs settle, in the same cycle they are applied.

A dropped or misrouted diagonal carry shows up as an error of a power of two. That error appears only for the operand pairs that set that particular cell's inputs, so a handful of chosen vectors could miss it. For this reason the bench sweeps all 256 operand pairs against an arithmetic reference, and it adds targeted checks for the zero, unit and maximum corners and for operand symmetry.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Default operand width of the multiplier
  parameter int unsigned CSA_WIDTH_DEFAULT = 4;

  // Largest product for a given operand width: (2^w - 1)^2
  function automatic longint unsigned csaMaxProduct(input int unsigned w);
    longint unsigned top;
    top = (longint'(1) << w) - 1;
    return top * top;
  endfunction

endpackage

// File: rtl/csaFullAdder.sv
module csaFullAdder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);

  logic halfSum;

  assign halfSum = a ^ b;
  assign sum     = halfSum ^ cin;
  assign cout    = (a & b) | (cin & halfSum);

endmodule

// File: rtl/csaAndRow.sv
module csaAndRow #(
  parameter int unsigned WIDTH = csa_pkg::CSA_WIDTH_DEFAULT
) (
  input  logic [WIDTH-1:0] mVec,
  input  logic             qBit,
  output logic [WIDTH-1:0] ppRow
);

  // One 2-input AND per multiplicand bit
  assign ppRow = mVec & {WIDTH{qBit}};

endmodule

// File: rtl/csaArray.sv
module csaArray #(
  parameter int unsigned WIDTH = csa_pkg::CSA_WIDTH_DEFAULT
) (
  input  logic [WIDTH-1:0][WIDTH-1:0] ppGrid,   // [row j][column k], weight j+k
  output logic [2*WIDTH-1:0]          product
);

  localparam int unsigned LAST_ROW = WIDTH - 1;

  // sumGrid[j][k]   : weight j+k
  // carryGrid[j][k] : weight j+k+1 (moves to column k of row j+1)
  logic [WIDTH-1:0][WIDTH-1:0] sumGrid;
  logic [WIDTH-1:0][WIDTH-1:0] carryGrid;
  logic [WIDTH-1:0]            rippleCarry;

  // Row 0 is the first partial product itself
  assign sumGrid[0]   = ppGrid[0];
  assign carryGrid[0] = '0;

  // Carry-save rows: no carry moves sideways inside a row
  genvar j, k;
  generate
    for (j = 1; j < WIDTH; j++) begin : g_row
      for (k = 0; k < WIDTH; k++) begin : g_cell
        logic sumFromAbove;
        if (k + 1 < WIDTH) begin : g_inner
          assign sumFromAbove = sumGrid[j-1][k+1];
        end else begin : g_edge
          assign sumFromAbove = 1'b0;
        end
        csaFullAdder u_fa (
          .a   (ppGrid[j][k]),
          .b   (sumFromAbove),
          .cin (carryGrid[j-1][k]),
          .sum (sumGrid[j][k]),
          .cout(carryGrid[j][k])
        );
      end
    end

    // Low product bits drop out of column 0 of each row
    for (j = 0; j < WIDTH; j++) begin : g_low
      assign product[j] = sumGrid[j][0];
    end

    // Final ripple stage merges the leftover sum and carry vectors
    assign rippleCarry[0] = 1'b0;
    for (k = 0; k + 1 < WIDTH; k++) begin : g_merge
      csaFullAdder u_fa (
        .a   (sumGrid[LAST_ROW][k+1]),
        .b   (carryGrid[LAST_ROW][k]),
        .cin (rippleCarry[k]),
        .sum (product[WIDTH+k]),
        .cout(rippleCarry[k+1])
      );
    end
  endgenerate

  assign product[2*WIDTH-1] = carryGrid[LAST_ROW][LAST_ROW] ^ rippleCarry[LAST_ROW];

endmodule

// File: rtl/csaMultiplier.sv
module csaMultiplier #(
  parameter int unsigned WIDTH = csa_pkg::CSA_WIDTH_DEFAULT
) (
  input  logic [WIDTH-1:0]   m,
  input  logic [WIDTH-1:0]   q,
  output logic [2*WIDTH-1:0] product
);

  localparam int unsigned PROD_W = 2 * WIDTH;
  localparam logic [PROD_W-1:0] MAX_PRODUCT = PROD_W'(csa_pkg::csaMaxProduct(WIDTH));

  logic [WIDTH-1:0][WIDTH-1:0] ppGrid;

  genvar j;
  generate
    for (j = 0; j < WIDTH; j++) begin : g_pp
      csaAndRow #(.WIDTH(WIDTH)) u_row (
        .mVec (m),
        .qBit (q[j]),
        .ppRow(ppGrid[j])
      );
    end
  endgenerate

  csaArray #(.WIDTH(WIDTH)) u_array (
    .ppGrid (ppGrid),
    .product(product)
  );

  always_comb begin
    // R1
    exact_product_chk: assert (product == PROD_W'(m) * PROD_W'(q))
      else $error("product %0d differs from %0d*%0d", product, m, q);
    // R2
    if (m == '0 || q == '0) begin
      zero_operand_chk: assert (product == '0)
        else $error("zero operand gave %0d", product);
    end
    // R4
    if (q == WIDTH'(1)) begin
      unit_q_chk: assert (product == PROD_W'(m))
        else $error("q=1 gave %0d for m=%0d", product, m);
    end
    // R4
    if (m == WIDTH'(1)) begin
      unit_m_chk: assert (product == PROD_W'(q))
        else $error("m=1 gave %0d for q=%0d", product, q);
    end
    // R5
    range_chk: assert (product <= MAX_PRODUCT)
      else $error("product %0d above maximum", product);
  end

endmodule

// File: tb/test_csaMultiplier.sv
module test_csaMultiplier;

  localparam int unsigned W  = 4;
  localparam int unsigned PW = 2 * W;

  typedef struct {
    logic [W-1:0]  mVal;
    logic [W-1:0]  qVal;
    logic [PW-1:0] expVal;
    string         tag;
    bit            lsbOnly;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  m = '0;
  logic [W-1:0]  q = '0;
  logic [PW-1:0] product;

  expItem_t expQueue[$];
  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;
  bit driverDone = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  csaMultiplier #(.WIDTH(W)) i_csaMultiplier (
    .m      (m),
    .q      (q),
    .product(product)
  );

  task automatic pushCheck(input int a, input int b, input int expected,
                           input string tag, input bit lsbOnly = 1'b0);
    expItem_t item;
    @(posedge clk);
    m <= W'(a);
    q <= W'(b);
    item.mVal    = W'(a);
    item.qVal    = W'(b);
    item.expVal  = PW'(expected);
    item.tag     = tag;
    item.lsbOnly = lsbOnly;
    expQueue.push_back(item);
  endtask

  // Monitor: samples mid-cycle, after the inputs driven at posedge settle
  always @(negedge clk) begin
    if (rstN && expQueue.size() > 0) begin
      expItem_t item;
      item = expQueue.pop_front();
      checkCount++;
      if (item.lsbOnly) begin
        if (product[0] !== item.expVal[0]) begin
          failCount++;
          $display("FAIL %s: m=%0d q=%0d lsb actual=%0b expected=%0b",
                   item.tag, item.mVal, item.qVal, product[0], item.expVal[0]);
        end
      end else if (product !== item.expVal) begin
        failCount++;
        $display("FAIL %s: m=%0d q=%0d actual=%0d expected=%0d",
                 item.tag, item.mVal, item.qVal, product, item.expVal);
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 20000) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycleCount);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN <= 1'b1;

    // reset state: both operands zero after reset (R2)
    pushCheck(0, 0, 0, "R2_reset");

    // R6: traced example pairs
    pushCheck(14, 11, 154, "R6");
    pushCheck(9, 5, 45, "R6");

    // R7: listed vectors
    pushCheck(0, 10, 0, "R7");
    pushCheck(5, 5, 25, "R7");
    pushCheck(12, 13, 156, "R7");
    pushCheck(15, 10, 150, "R7");

    // R2: zero in either position
    for (int v = 0; v < 16; v++) begin
      pushCheck(v, 0, 0, "R2");
      pushCheck(0, v, 0, "R2");
    end

    // R4: unit operand in either position
    for (int v = 0; v < 16; v++) begin
      pushCheck(v, 1, v, "R4");
      pushCheck(1, v, v, "R4");
    end

    // R5: maximum corner
    pushCheck(15, 15, 225, "R5");
    pushCheck(15, 14, 210, "R5");

    // R3: lsb follows both operand lsbs
    pushCheck(3, 5, 1, "R3", 1'b1);
    pushCheck(2, 5, 0, "R3", 1'b1);
    pushCheck(3, 6, 0, "R3", 1'b1);
    pushCheck(8, 4, 0, "R3", 1'b1);

    // R8: swapped operands give the same reference
    for (int a = 0; a < 16; a += 3) begin
      for (int b = 0; b < 16; b += 5) begin
        pushCheck(b, a, a * b, "R8");
      end
    end

    // R1: exhaustive sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        pushCheck(a, b, a * b, "R1");
      end
    end

    driverDone = 1'b1;
    @(posedge clk);
    while (expQueue.size() > 0) @(posedge clk);
    @(posedge clk);
    finishRun();
  end

endmodule